// File: doc/BRIEF.md
# Redundant Reference Clock Supervisor Register Block

This block is the host-facing byte register file of a telecom timing card that follows one of two redundant reference clocks. Through a synchronous strobe bus of eight byte-wide locations it holds the settings of the timing loop: operating mode, loop filter, reference choice, output enables and transmit-rate codes. Each setting is driven straight out to the clocking logic. It also exposes the live state of four alarm inputs: primary loss of signal, secondary loss of signal, loop holdover and loop unlock.

Every alarm input is brought into the bus clock domain by a two-flop synchronizer. Each input then has its own detector for the 0-to-1 and the 1-to-0 transition. A detected transition sets a sticky cause bit, and a level interrupt stays high while any cause bit is pending. Host software reads the cause location once, which returns and clears the whole set.

A small arming state machine protects against false events after reset. Its states are FILL_A, FILL_B, SETTLE and ARMED. Its transitions are FILL_A to FILL_B, FILL_B to SETTLE and SETTLE to ARMED, one per clock, and ARMED holds until reset. Transitions are only recorded in ARMED, so alarm levels that are already present when reset is released never post a cause.

Top module: `clksup_regblock`

## Requirements
- R1: After reset, the registers read as follows: offset 0 reads 0x00, offset 1 reads only the in-use reference in bit3, the low nibble of offset 2 is 0, offset 3 reads 0x00, offset 4 reads 0x02 with `pll_rst_n` high, offset 6 reads 0x00, and `irq` is low.
- R2: Offset 0 is a control byte. Bit7 drives `hw_switch_en`. Bit6 drives `switch_on_holdover`. Bits5:4 drive `pll_mode` (00 normal, 01 holdover, 10 free-run). Bit2 drives `filter_6hz`. Bits1:0 drive `hirate_sel`. Every written field reads back.
- R3: Writing 1 to bit3 of offset 0 makes `ref_align` high for exactly one cycle, starting the cycle after the write. Bit3 always reads 0.
- R4: Bit1 of offset 4 drives `pll_rst_n`, so writing 0 asserts the loop reset. All other bits of offset 4 read 0.
- R5: Read-only bits ignore writes. These are bit3 of offset 1 (follows `ref_in_use`) and the upper nibble of offset 2 (bit7 primary lost, bit6 secondary lost, bit5 holdover, bit4 unlock, all synchronized). Offsets 5, 6 and 7 are read-only in full, and a write to offset 6 leaves pending causes unchanged.
- R6: Offset 5 returns the VERSION parameter. Offset 7 returns the IRQ_LINE parameter in bits3:0, with 0 in bits7:4.
- R7: A transition on an alarm input sets a sticky cause bit in offset 6. The bit is set 3 clocks after the input changes, and it reads back from the fourth bus cycle on. The cause bits are: bit0 primary rise, bit1 primary fall, bit2 secondary rise, bit3 secondary fall, bit4 holdover rise, bit5 holdover fall, bit6 unlock rise, bit7 unlock fall.
- R8: A read of offset 6 returns every pending cause bit and clears all of them.
- R9: A transition detected in the same cycle as a read of offset 6 is not returned by that read, and it stays pending afterwards.
- R10: `irq` is high whenever any cause bit is pending, and falls only after a read of offset 6.
- R11: Alarm levels already present at reset release post no cause bit.
- R12: Offset 1 bit0 drives `redund_sel_sec` and bit1 drives `ref_freq_hi`. Offset 2 bits3:0 drive `out_en`. Offset 3 drives `xmit_sel`. All of these read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, which has a side effect on offset 6 |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| alm_pri_los | input | 1 | Primary reference loss of signal |
| alm_sec_los | input | 1 | Secondary reference loss of signal |
| alm_holdover | input | 1 | Loop in holdover |
| alm_unlock | input | 1 | Loop unlocked |
| ref_in_use | input | 1 | Reference currently tracked (0 primary, 1 secondary) |
| hw_switch_en | output | 1 | Automatic switchover enable |
| switch_on_holdover | output | 1 | Switchover trigger (1 holdover, 0 lost clock) |
| pll_mode | output | 2 | Loop operating mode |
| ref_align | output | 1 | One-cycle reference-align pulse |
| filter_6hz | output | 1 | Loop filter select (1 is 6 Hz, 0 is 12 Hz) |
| hirate_sel | output | 2 | High-rate transmit code |
| redund_sel_sec | output | 1 | Redundant reference select |
| ref_freq_hi | output | 1 | Reference frequency (0 is 8 kHz, 1 is 19.44 MHz) |
| out_en | output | 4 | Clock output enables |
| xmit_sel | output | 8 | Transmit clock selection byte |
| pll_rst_n | output | 1 | Active-low loop reset |
| irq | output | 1 | Level interrupt |

## Verification
The sharpest corner is a transition that lands in the same cycle as a cause read. A design that clears after merging would drop that event silently, and one that returns it in the read would report it twice or out of order. Alarms held high across reset release are also checked: a design without arming would post a spurious rise cause and raise `irq` at once. Writes aimed at read-only bits, at the version location and at the cause location are checked too, since a careless decode would let them corrupt status or wipe pending causes. Finally, the align strobe must read back 0 and pulse for exactly one cycle, and a design that stored it would hold the align request on.

// File: rtl/clksup_pkg.sv
package clksup_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int ALARM_N  = 4;
    localparam int CAUSE_W  = 2 * ALARM_N;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_REFSEL = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_STATEN = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_XMIT   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_PLLRST = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_VER    = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_CAUSE  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_IRQNUM = 3'd7;

    // alarm vector index order
    localparam int AL_PRI  = 0;
    localparam int AL_SEC  = 1;
    localparam int AL_HOLD = 2;
    localparam int AL_UNLK = 3;

    typedef enum logic [1:0] {
        SYNC_FILL_A = 2'd0,
        SYNC_FILL_B = 2'd1,
        SYNC_SETTLE = 2'd2,
        SYNC_ARMED  = 2'd3
    } arm_state_t;
endpackage

// File: rtl/clksup_sync.sv
module clksup_sync
    import clksup_pkg::*;
#(
    parameter int WIDTH = ALARM_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic             armed
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    arm_state_t state_q, state_d;

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= async_in[g];
                sync_q[g] <= meta_q[g];
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SYNC_FILL_A;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_FILL_A: state_d = SYNC_FILL_B;
            SYNC_FILL_B: state_d = SYNC_SETTLE;
            SYNC_SETTLE: state_d = SYNC_ARMED;
            SYNC_ARMED:  state_d = SYNC_ARMED;
            default:     state_d = SYNC_FILL_A;
        endcase
    end

    // outputs
    always_comb begin
        sync_out = sync_q;
        armed    = (state_q == SYNC_ARMED);
    end

    AST_ARM_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed); // R11
endmodule

// File: rtl/clksup_cause.sv
module clksup_cause
    import clksup_pkg::*;
#(
    parameter int WIDTH = ALARM_N,
    localparam int CW   = 2 * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic             armed,
    input  logic             rd_clr,
    output logic [CW-1:0]    pending
);
    logic [WIDTH-1:0] prev_q;
    logic [CW-1:0]    edge_vec;
    logic [CW-1:0]    pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_edge
        assign edge_vec[2*g]   = armed &  level[g] & ~prev_q[g];
        assign edge_vec[2*g+1] = armed & ~level[g] &  prev_q[g];
    end

    // clear first, then merge new edges so nothing coincident is lost
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (rd_clr ? '0 : pend_q) | edge_vec;
    end

    assign pending = pend_q;

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && edge_vec == '0) |=> pending == '0); // R8
    AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vec != '0) |=> ((pending & $past(edge_vec)) == $past(edge_vec))); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (($past(pending) & ~pending) == '0)); // R7
endmodule

// File: rtl/clksup_ctrl.sv
module clksup_ctrl
    import clksup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [1:0]        refsel_q,
    output logic [3:0]        outen_q,
    output logic [DATA_W-1:0] xmit_q,
    output logic              rst_bit_q,
    output logic              align_pulse
);
    localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hF7;
    localparam int ALIGN_BIT = 3;
    localparam int RST_BIT   = 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            refsel_q    <= '0;
            outen_q     <= '0;
            xmit_q      <= '0;
            rst_bit_q   <= 1'b1;
            align_pulse <= 1'b0;
        end else begin
            align_pulse <= wr && (addr == OFS_CTRL) && wdata[ALIGN_BIT];
            if (wr) begin
                unique case (addr)
                    OFS_CTRL:   ctrl_q    <= wdata & CTRL_KEEP;
                    OFS_REFSEL: refsel_q  <= wdata[1:0];
                    OFS_STATEN: outen_q   <= wdata[3:0];
                    OFS_XMIT:   xmit_q    <= wdata;
                    OFS_PLLRST: rst_bit_q <= wdata[RST_BIT];
                    default: ;
                endcase
            end
        end
    end

    AST_ALIGN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        align_pulse |=> !align_pulse || $past(wr && addr == OFS_CTRL && wdata[ALIGN_BIT])); // R3
    AST_PLL_RST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_PLLRST) |=> rst_bit_q == $past(wdata[RST_BIT])); // R4
endmodule

// File: rtl/clksup_regblock.sv
module clksup_regblock
    import clksup_pkg::*;
#(
    parameter logic [7:0] VERSION  = 8'h21,
    parameter logic [3:0] IRQ_LINE = 4'h5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        alm_pri_los,
    input  logic        alm_sec_los,
    input  logic        alm_holdover,
    input  logic        alm_unlock,
    input  logic        ref_in_use,
    output logic        hw_switch_en,
    output logic        switch_on_holdover,
    output logic [1:0]  pll_mode,
    output logic        ref_align,
    output logic        filter_6hz,
    output logic [1:0]  hirate_sel,
    output logic        redund_sel_sec,
    output logic        ref_freq_hi,
    output logic [3:0]  out_en,
    output logic [7:0]  xmit_sel,
    output logic        pll_rst_n,
    output logic        irq
);
    logic [ALARM_N-1:0] alm_raw, alm_sync;
    logic               armed;
    logic               rd_clr;
    logic [CAUSE_W-1:0] cause_q;
    logic [DATA_W-1:0]  ctrl_q, xmit_q;
    logic [1:0]         refsel_q;
    logic [3:0]         outen_q;
    logic               rst_bit_q;
    logic               align_pulse;

    always_comb begin
        alm_raw          = '0;
        alm_raw[AL_PRI]  = alm_pri_los;
        alm_raw[AL_SEC]  = alm_sec_los;
        alm_raw[AL_HOLD] = alm_holdover;
        alm_raw[AL_UNLK] = alm_unlock;
    end

    assign rd_clr = bus_rd && (bus_addr == OFS_CAUSE);

    clksup_sync #(.WIDTH(ALARM_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (alm_raw),
        .sync_out (alm_sync),
        .armed    (armed)
    );

    clksup_cause #(.WIDTH(ALARM_N)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (alm_sync),
        .armed   (armed),
        .rd_clr  (rd_clr),
        .pending (cause_q)
    );

    clksup_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .ctrl_q      (ctrl_q),
        .refsel_q    (refsel_q),
        .outen_q     (outen_q),
        .xmit_q      (xmit_q),
        .rst_bit_q   (rst_bit_q),
        .align_pulse (align_pulse)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL:   bus_rdata = ctrl_q;
            OFS_REFSEL: bus_rdata = {4'b0, ref_in_use, 1'b0, refsel_q};
            OFS_STATEN: bus_rdata = {alm_sync[AL_PRI], alm_sync[AL_SEC],
                                     alm_sync[AL_HOLD], alm_sync[AL_UNLK], outen_q};
            OFS_XMIT:   bus_rdata = xmit_q;
            OFS_PLLRST: bus_rdata = {6'b0, rst_bit_q, 1'b0};
            OFS_VER:    bus_rdata = VERSION;
            OFS_CAUSE:  bus_rdata = cause_q;
            OFS_IRQNUM: bus_rdata = {4'b0, IRQ_LINE};
            default:    bus_rdata = '0;
        endcase
    end

    always_comb begin
        hw_switch_en       = ctrl_q[7];
        switch_on_holdover = ctrl_q[6];
        pll_mode           = ctrl_q[5:4];
        filter_6hz         = ctrl_q[2];
        hirate_sel         = ctrl_q[1:0];
        ref_align          = align_pulse;
        redund_sel_sec     = refsel_q[0];
        ref_freq_hi        = refsel_q[1];
        out_en             = outen_q;
        xmit_sel           = xmit_q;
        pll_rst_n          = rst_bit_q;
        irq                = |cause_q;
    end

    AST_IRQ_FALLS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_clr)); // R10
    AST_QUIET_UNTIL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> cause_q == '0); // R11
    AST_CAUSE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && cause_q != '0) |=> cause_q != '0); // R5
endmodule

// File: tb/tb_clksup_regblock.sv
module tb_clksup_regblock;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] VER = 8'h21;
    localparam logic [3:0] IRQN = 4'h5;
    localparam int NVEC = 14;
    // {addr[2:0], wdata[7:0], expected readback[7:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {3'd0, 8'hA5, 8'hA5}, {3'd0, 8'h5F, 8'h57},
        {3'd1, 8'hFF, 8'h03}, {3'd1, 8'h02, 8'h02},
        {3'd2, 8'hFF, 8'h0F}, {3'd2, 8'hA6, 8'h06},
        {3'd3, 8'h3C, 8'h3C}, {3'd3, 8'hC3, 8'hC3},
        {3'd4, 8'hFF, 8'h02}, {3'd4, 8'h00, 8'h00},
        {3'd4, 8'h02, 8'h02}, {3'd5, 8'h00, VER},
        {3'd7, 8'hFF, {4'h0, IRQN}}, {3'd6, 8'hFF, 8'h00}
    };

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic a_pri = 0, a_sec = 0, a_hold = 0, a_unl = 0, ref_use = 0;
    logic hw_sw, sw_hold, align, f6, rsec, rfreq, prst_n, irq;
    logic [1:0] mode, hir;
    logic [3:0] oen;
    logic [7:0] xsel;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksup_regblock #(.VERSION(VER), .IRQ_LINE(IRQN)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alm_pri_los(a_pri), .alm_sec_los(a_sec), .alm_holdover(a_hold),
        .alm_unlock(a_unl), .ref_in_use(ref_use),
        .hw_switch_en(hw_sw), .switch_on_holdover(sw_hold), .pll_mode(mode),
        .ref_align(align), .filter_6hz(f6), .hirate_sel(hir),
        .redund_sel_sec(rsec), .ref_freq_hi(rfreq), .out_en(oen),
        .xmit_sel(xsel), .pll_rst_n(prst_n), .irq(irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        tick(1);
        bus_rd = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        // R11: primary alarm already high through reset
        a_pri = 1;
        tick(3);
        rst_n = 1;
        tick(6);
        // R1 reset values
        rd(3'd0, d); check("R1 ofs0", d, 8'h00);
        rd(3'd1, d); check("R1 ofs1", d, 8'h00);
        rd(3'd3, d); check("R1 ofs3", d, 8'h00);
        rd(3'd4, d); check("R1 ofs4", d, 8'h02);
        check("R1 pll_rst_n", {7'b0, prst_n}, 8'h01);
        check("R11 irq quiet", {7'b0, irq}, 8'h00);
        rd(3'd2, d); check("R5 live pri status", d, 8'h80);
        rd(3'd6, d); check("R11 no cause at arm", d, 8'h00);
        a_pri = 0;
        tick(3);
        rd(3'd6, d); check("R7 primary fall bit1", d, 8'h02);

        // table walk: R2 R4 R5 R6 R12
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            rd(VEC[i][18:16], d);
            check($sformatf("R2/R4/R5/R6/R12 vec%0d", i), d, VEC[i][7:0]);
        end

        // R2 output fields
        wr(3'd0, 8'hA5);
        check("R2 fields", {hw_sw, sw_hold, mode, 1'b0, f6, hir}, 8'hA5);
        // R12 outputs
        check("R12 refsel", {6'b0, rfreq, rsec}, 8'h02);
        check("R12 out_en", {4'b0, oen}, 8'h06);
        check("R12 xmit_sel", xsel, 8'hC3);
        // R4 reset asserted
        wr(3'd4, 8'hFD);
        check("R4 pll_rst_n low", {7'b0, prst_n}, 8'h00);
        wr(3'd4, 8'h02);
        // R5 in-use bit
        ref_use = 1;
        wr(3'd1, 8'h00);
        rd(3'd1, d); check("R5 ref_in_use bit3", d, 8'h08);
        ref_use = 0;

        // R3 align strobe
        bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'h08;
        tick(1);
        bus_wr = 0;
        check("R3 pulse high", {7'b0, align}, 8'h01);
        tick(1);
        check("R3 pulse one cycle", {7'b0, align}, 8'h00);
        rd(3'd0, d); check("R3 reads zero", d, 8'h00);

        // R7 R10 R8 holdover rise
        a_hold = 1;
        tick(3);
        check("R10 irq set", {7'b0, irq}, 8'h01);
        rd(3'd6, d); check("R7 holdover rise bit4", d, 8'h10);
        check("R10 irq cleared", {7'b0, irq}, 8'h00);
        rd(3'd6, d); check("R8 cleared", d, 8'h00);

        // two simultaneous rises
        a_unl = 1; a_sec = 1;
        tick(3);
        rd(3'd2, d); check("R5 live status nibble", d, 8'h76);
        rd(3'd6, d); check("R7 sec+unlock rise", d, 8'h44);

        // R5 write to cause ignored
        a_hold = 0;
        tick(3);
        wr(3'd6, 8'hFF);
        check("R5 cause survives write", {7'b0, irq}, 8'h01);
        rd(3'd6, d); check("R5 holdover fall kept", d, 8'h20);

        // R9 edge coincident with read
        a_pri = 1;
        tick(2);
        rd(3'd6, d); check("R9 read excludes new edge", d, 8'h00);
        check("R9 irq after read", {7'b0, irq}, 8'h01);
        rd(3'd6, d); check("R9 edge kept", d, 8'h01);

        // falls together
        a_pri = 0; a_sec = 0; a_unl = 0;
        tick(3);
        rd(3'd6, d); check("R7 multi fall", d, 8'h8A);

        finish_run();
    end
endmodule